// File: doc/BRIEF.md
# Pipelined burst synchronous SRAM

A synthesizable single-port synchronous static memory with byte-lane writes and a two-register read path. An access address is taken into a register on one rising edge, and the word it selects is placed in the output register on the following edge. A cycle can be opened by either of two active-low address strobes: a processor strobe, which always begins a read, and a controller strobe, which samples the write controls on the same edge. Once a cycle is open, later edges with both strobes high continue it as a four-beat burst. The burst advance input moves the burst forward through an interleaved or a linear order.

Three chip selects qualify every start. The master select gates the processor strobe itself. The other two only decide whether a start becomes an access or a deselect. Writes are decoded per byte lane, and a global write overrides the per-lane controls. The output drive flag is a registered read-valid bit combined with an asynchronous active-low output enable. The flag is forced off for the cycle after any write. The memory depth is set by the address width parameter.

Top module: `sram_pipe_burst`

## Requirements
- R1: An edge with `proc_stb_n`=0 and `sel0_n`=0 is a processor start. When `sel1`=1 and `sel2_n`=0 it begins a read at `addr_i`, and on that edge `ctrl_stb_n`, `adv_n`, `gw_n`, `bwe_n` and `lane_wr_n` have no effect. Those write controls are sampled again on the edges that follow.
- R2: Data read by an access on rising edge k appears on `dq_o`, with `drive_o`=1, after edge k+1, provided `oe_n` is 0 and edge k+1 performs no write.
- R3: A controller start needs `ctrl_stb_n`=0 while the processor strobe is not in effect. The write controls are sampled on that same edge. When both strobes are low with `sel0_n`=0, the processor start wins and the edge is a read.
- R4: While `sel0_n`=1, a low `proc_stb_n` is treated as high. If `ctrl_stb_n` is also high, an open burst continues. If `ctrl_stb_n` is low, the edge is a controller start.
- R5: Lane i is bits [8i+7:8i]. With `gw_n`=0 every lane is written. With `gw_n`=1 and `bwe_n`=0, exactly the lanes whose `lane_wr_n` bit is 0 are written. In every other case the access is a read.
- R6: A start edge on which any of `sel0_n`=0, `sel1`=1 or `sel2_n`=0 does not hold is a deselect. It makes no access. `drive_o` is 0 after the next edge. Continuation edges then do nothing until the next start.
- R7: A continuation edge (both strobes effectively high, cycle open) with `adv_n`=0 moves to the next burst beat. With `adv_n`=1 it repeats the current beat. The upper address bits stay fixed. For start offset s and beat n, the low two bits are s XOR n when `linear_i`=0, and (s+n) mod 4 when `linear_i`=1.
- R8: After any edge that writes at least one lane, `drive_o` is 0 for the following cycle, whatever `oe_n` is.
- R9: `drive_o` follows `oe_n` without waiting for a clock edge. It is 0 whenever `oe_n`=1.
- R10: A write is committed on its own edge. A later read of that address returns the new bytes in the written lanes and the old bytes in the others.
- R11: While `rst` is high and after it falls, `drive_o` is 0 and no cycle is open. Continuation edges neither read nor write until a start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| addr_i | input | ADDR_W | Word address taken on a start |
| proc_stb_n | input | 1 | Processor address strobe, active low |
| ctrl_stb_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| sel0_n | input | 1 | Master chip select, active low |
| sel1 | input | 1 | Chip select, active high |
| sel2_n | input | 1 | Chip select, active low |
| gw_n | input | 1 | Global write of all lanes, active low |
| bwe_n | input | 1 | Enable for per-lane writes, active low |
| lane_wr_n | input | LANES | Per-lane write strobes, active low |
| linear_i | input | 1 | Burst order: 1 linear, 0 interleaved |
| oe_n | input | 1 | Asynchronous output enable, active low |
| wdata_i | input | LANES*LANE_W | Write data |
| dq_o | output | LANES*LANE_W | Read data register |
| drive_o | output | 1 | Output drivers enabled (0 means high impedance) |

## Verification
The bench sweeps every start address in both burst orders and all sixteen lane-strobe patterns. It stacks the two strobes against each other and against the master select, and it places writes directly after reads. A design that let the processor start sample the write strobes would corrupt words the bench later reads back. One that let the master select block controller starts, or that failed to gate the processor strobe, would open or drop bursts the bench does not expect. Getting the wrap arithmetic of either burst order wrong shows up as stale data on some offset. A read pipeline that stays driving on the cycle after a write, or that moves by one stage, is caught on the drive flag and the data word at the exact sampled cycle.

// File: rtl/sram_pb_pkg.sv
`timescale 1ns/1ps
package sram_pb_pkg;

  // What one rising edge does to the access state
  typedef enum logic [1:0] {
    EDGE_IDLE  = 2'd0,
    EDGE_DESEL = 2'd1,
    EDGE_START = 2'd2,
    EDGE_CONT  = 2'd3
  } edge_kind_t;

  // Low two address bits of burst beat `step` from start offset `first`
  function automatic logic [1:0] burst_slot(input logic [1:0] first,
                                            input logic [1:0] step,
                                            input logic       linear);
    logic [1:0] sum;
    sum = first + step;
    return linear ? sum : (first ^ step);
  endfunction

endpackage

// File: rtl/sram_pb_ctrl.sv
`timescale 1ns/1ps
module sram_pb_ctrl
  import sram_pb_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              proc_stb_n,
  input  logic              ctrl_stb_n,
  input  logic              adv_n,
  input  logic              sel0_n,
  input  logic              sel1,
  input  logic              sel2_n,
  input  logic              gw_n,
  input  logic              bwe_n,
  input  logic [LANES-1:0]  lane_wr_n,
  input  logic              linear_i,
  output logic              acc_valid,
  output logic [ADDR_W-1:0] acc_addr,
  output logic [LANES-1:0]  acc_we
);

  localparam int HI_W = ADDR_W - 2;

  edge_kind_t       kind;
  logic             proc_eff;
  logic             strobe;
  logic             all_en;
  logic [LANES-1:0] we_dec;
  logic [1:0]       step_nxt;

  logic             active_q;
  logic [HI_W-1:0]  hi_q;
  logic [1:0]       first_q;
  logic [1:0]       step_q;

  // Strobe priority and chip-select qualification
  always_comb begin
    proc_eff = !proc_stb_n && !sel0_n;
    strobe   = proc_eff || !ctrl_stb_n;
    all_en   = !sel0_n && sel1 && !sel2_n;
    if (strobe && all_en)  kind = EDGE_START;
    else if (strobe)       kind = EDGE_DESEL;
    else if (active_q)     kind = EDGE_CONT;
    else                   kind = EDGE_IDLE;
  end

  // Write decode: global override, then per-lane
  always_comb begin
    we_dec = '0;
    if (!gw_n)       we_dec = '1;
    else if (!bwe_n) we_dec = ~lane_wr_n;
  end

  always_comb begin
    step_nxt = step_q;
    if (kind == EDGE_CONT && !adv_n) step_nxt = step_q + 2'd1;
  end

  always_comb begin
    acc_valid = (kind == EDGE_START) || (kind == EDGE_CONT);
    if (kind == EDGE_START) acc_addr = addr_i;
    else                    acc_addr = {hi_q, burst_slot(first_q, step_nxt, linear_i)};
    if (kind == EDGE_CONT || (kind == EDGE_START && !proc_eff)) acc_we = we_dec;
    else                                                        acc_we = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      hi_q     <= '0;
      first_q  <= '0;
      step_q   <= '0;
    end else begin
      case (kind)
        EDGE_START: begin
          active_q <= 1'b1;
          hi_q     <= addr_i[ADDR_W-1:2];
          first_q  <= addr_i[1:0];
          step_q   <= 2'd0;
        end
        EDGE_DESEL: active_q <= 1'b0;
        EDGE_CONT:  step_q   <= step_nxt;
        default:    ;
      endcase
    end
  end

endmodule

// File: rtl/sram_pb_array.sv
`timescale 1ns/1ps
module sram_pb_array #(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4,
  parameter int LANE_W = 8
) (
  input  logic                    clk,
  input  logic                    ren,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANES-1:0]        we,
  input  logic [LANES*LANE_W-1:0] wdata,
  output logic [LANES*LANE_W-1:0] rdata
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [ADDR_W-1:0] raddr_q;

  // Stage one: read address register
  always_ff @(posedge clk) begin
    if (ren) raddr_q <= addr;
  end

  // One simple-dual-port memory per byte lane; stage two is its output register
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
      if (we[i]) mem[addr] <= wdata[i*LANE_W +: LANE_W];
      rdata[i*LANE_W +: LANE_W] <= mem[raddr_q];
    end
  end

endmodule

// File: rtl/sram_pb_outpipe.sv
`timescale 1ns/1ps
module sram_pb_outpipe (
  input  logic clk,
  input  logic rst,
  input  logic rd_req,
  input  logic wr_now,
  input  logic oe_n,
  output logic drive_o
);

  logic pend_q;
  logic drv_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= 1'b0;
      drv_q  <= 1'b0;
    end else begin
      pend_q <= rd_req;
      drv_q  <= pend_q && !wr_now;
    end
  end

  // Asynchronous output enable on top of the registered valid
  assign drive_o = drv_q && !oe_n;

endmodule

// File: rtl/sram_pipe_burst.sv
`timescale 1ns/1ps
module sram_pipe_burst #(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4,
  parameter int LANE_W = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic                    proc_stb_n,
  input  logic                    ctrl_stb_n,
  input  logic                    adv_n,
  input  logic                    sel0_n,
  input  logic                    sel1,
  input  logic                    sel2_n,
  input  logic                    gw_n,
  input  logic                    bwe_n,
  input  logic [LANES-1:0]        lane_wr_n,
  input  logic                    linear_i,
  input  logic                    oe_n,
  input  logic [LANES*LANE_W-1:0] wdata_i,
  output logic [LANES*LANE_W-1:0] dq_o,
  output logic                    drive_o
);

  logic              acc_valid;
  logic [ADDR_W-1:0] acc_addr;
  logic [LANES-1:0]  acc_we;
  logic              wr_now;
  logic              rd_req;

  assign wr_now = |acc_we;
  assign rd_req = acc_valid && !wr_now;

  sram_pb_ctrl #(.ADDR_W(ADDR_W), .LANES(LANES)) ctrl_i (
    .clk        (clk),
    .rst        (rst),
    .addr_i     (addr_i),
    .proc_stb_n (proc_stb_n),
    .ctrl_stb_n (ctrl_stb_n),
    .adv_n      (adv_n),
    .sel0_n     (sel0_n),
    .sel1       (sel1),
    .sel2_n     (sel2_n),
    .gw_n       (gw_n),
    .bwe_n      (bwe_n),
    .lane_wr_n  (lane_wr_n),
    .linear_i   (linear_i),
    .acc_valid  (acc_valid),
    .acc_addr   (acc_addr),
    .acc_we     (acc_we)
  );

  sram_pb_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) array_i (
    .clk   (clk),
    .ren   (rd_req),
    .addr  (acc_addr),
    .we    (acc_we),
    .wdata (wdata_i),
    .rdata (dq_o)
  );

  sram_pb_outpipe outpipe_i (
    .clk     (clk),
    .rst     (rst),
    .rd_req  (rd_req),
    .wr_now  (wr_now),
    .oe_n    (oe_n),
    .drive_o (drive_o)
  );

endmodule

// File: rtl/sram_pipe_burst_chk.sv
`timescale 1ns/1ps
module sram_pipe_burst_chk #(
  parameter int LANES = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             proc_stb_n,
  input logic             ctrl_stb_n,
  input logic             sel0_n,
  input logic             sel1,
  input logic             sel2_n,
  input logic             gw_n,
  input logic             oe_n,
  input logic             drive_o,
  input logic             acc_valid,
  input logic [LANES-1:0] acc_we
);

  logic desel;
  logic desel_q;

  assign desel = ((!proc_stb_n && !sel0_n) || !ctrl_stb_n) && !(!sel0_n && sel1 && !sel2_n);

  always_ff @(posedge clk) begin
    if (rst) desel_q <= 1'b0;
    else     desel_q <= desel;
  end

  AST_RESET_DARK: assert property (@(posedge clk) rst |=> !drive_o); // R11
  AST_OE_GATES: assert property (@(posedge clk) disable iff (rst) oe_n |-> !drive_o); // R9
  AST_PROC_NO_WRITE: assert property (@(posedge clk) disable iff (rst) (!proc_stb_n && !sel0_n) |-> (acc_we == '0)); // R1
  AST_CTRL_WRITE: assert property (@(posedge clk) disable iff (rst) (!ctrl_stb_n && proc_stb_n && !sel0_n && sel1 && !sel2_n && !gw_n) |-> (&acc_we)); // R3
  AST_DESEL_NO_ACCESS: assert property (@(posedge clk) disable iff (rst) desel |-> !acc_valid); // R6
  AST_DESEL_DARK: assert property (@(posedge clk) disable iff (rst) desel_q |=> !drive_o); // R6
  AST_WRITE_MUTES: assert property (@(posedge clk) disable iff (rst) (|acc_we) |=> !drive_o); // R8

endmodule

bind sram_pipe_burst sram_pipe_burst_chk #(.LANES(LANES)) chk_i (
  .clk        (clk),
  .rst        (rst),
  .proc_stb_n (proc_stb_n),
  .ctrl_stb_n (ctrl_stb_n),
  .sel0_n     (sel0_n),
  .sel1       (sel1),
  .sel2_n     (sel2_n),
  .gw_n       (gw_n),
  .oe_n       (oe_n),
  .drive_o    (drive_o),
  .acc_valid  (acc_valid),
  .acc_we     (acc_we)
);

// File: tb/sram_pipe_burst_tb.sv
`timescale 1ns/1ps
module sram_pipe_burst_tb_top;

  localparam int AW    = 6;
  localparam int NW    = 1 << AW;

  logic          clk = 1'b0;
  logic          rst;
  logic [AW-1:0] addr;
  logic          proc_n, ctrl_n, adv_n, s0n, s1, s2n, gw_n, bwe_n, lin, oe_n;
  logic [3:0]    lane_n;
  logic [31:0]   wd;
  logic [31:0]   dq_o;
  logic          drive_o;

  always #2 clk = ~clk;

  sram_pipe_burst #(.ADDR_W(AW), .LANES(4), .LANE_W(8)) dut_i (
    .clk(clk), .rst(rst), .addr_i(addr), .proc_stb_n(proc_n), .ctrl_stb_n(ctrl_n),
    .adv_n(adv_n), .sel0_n(s0n), .sel1(s1), .sel2_n(s2n), .gw_n(gw_n), .bwe_n(bwe_n),
    .lane_wr_n(lane_n), .linear_i(lin), .oe_n(oe_n), .wdata_i(wd),
    .dq_o(dq_o), .drive_o(drive_o)
  );

  int n_tests = 0;
  int n_fail  = 0;

  // Reference state built from the requirements
  logic [31:0] mem_m [NW];
  bit          m_active;
  logic [3:0]  m_hi;
  logic [1:0]  m_first, m_step;
  bit          pend_rd;
  logic [31:0] pend_data;
  logic [31:0] last_dq;

  function automatic logic [31:0] pat(input int a, input int s);
    return (32'(a) * 32'h0103_0507) ^ (32'(s) * 32'h9E37_79B9) ^ 32'h5A5A_0000;
  endfunction

  function automatic logic [1:0] beat(input logic [1:0] f, input logic [1:0] n, input logic l);
    logic [1:0] r;
    if (l) r = 2'((int'(f) + int'(n)) % 4);
    else   r = f ^ n;
    return r;
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic idle();
    proc_n = 1; ctrl_n = 1; adv_n = 1; s0n = 0; s1 = 1; s2n = 0;
    gw_n = 1; bwe_n = 1; lane_n = 4'hF; lin = 0; oe_n = 0; wd = '0; addr = '0;
  endtask

  // One rising edge with the current inputs, then checks at the falling edge
  task automatic tick(input string tag);
    bit pe, str, allen, acc, ndrv;
    logic [3:0]    we, dec;
    logic [AW-1:0] ad;
    logic [31:0]   ndq;
    @(posedge clk);
    acc = 0; we = '0; ad = '0; ndrv = 0; ndq = '0;
    if (rst) begin
      m_active = 0; m_step = 0; pend_rd = 0;
    end else begin
      pe    = !proc_n && !s0n;
      str   = pe || !ctrl_n;
      allen = !s0n && s1 && !s2n;
      dec   = !gw_n ? 4'hF : (!bwe_n ? ~lane_n : 4'h0);
      if (str && allen) begin
        acc = 1; ad = addr; m_hi = addr[AW-1:2]; m_first = addr[1:0];
        m_step = 0; m_active = 1; we = pe ? 4'h0 : dec;
      end else if (str) begin
        m_active = 0;
      end else if (m_active) begin
        acc = 1;
        if (!adv_n) m_step = m_step + 2'd1;
        ad = {m_hi, beat(m_first, m_step, lin)};
        we = dec;
      end
      for (int i = 0; i < 4; i++)
        if (we[i]) mem_m[ad][i*8 +: 8] = wd[i*8 +: 8];
      ndrv      = pend_rd && (we == 4'h0);
      ndq       = pend_data;
      pend_rd   = acc && (we == 4'h0);
      pend_data = mem_m[ad];
    end
    last_dq = ndq;
    @(negedge clk);
    check(drive_o === (ndrv && !oe_n), tag, "drive_o", {31'd0, drive_o}, {31'd0, ndrv && !oe_n});
    if (ndrv && !oe_n) check(dq_o === ndq, tag, "dq_o", dq_o, ndq);
  endtask

  task automatic proc_read(input int a, input bit l, input string tag);
    idle(); lin = l; proc_n = 0; addr = AW'(a); tick(tag);
    for (int k = 0; k < 3; k++) begin idle(); lin = l; adv_n = 0; tick(tag); end
    idle(); lin = l; tick(tag);
  endtask

  initial begin
    rst = 1; idle();
    // R11: quiet during reset
    for (int k = 0; k < 3; k++) tick("R11");
    rst = 0;

    // R5 R10: fill the array with global writes from controller starts
    for (int a = 0; a < NW; a++) begin
      idle(); ctrl_n = 0; gw_n = 0; addr = AW'(a); wd = pat(a, 1); tick("R5");
    end
    idle(); tick("R10");

    // R6: deselect through each secondary select, then continuation edges must do nothing
    idle(); ctrl_n = 0; addr = 6'd8; tick("R6");
    idle(); ctrl_n = 0; s1 = 0; tick("R6");
    for (int k = 0; k < 3; k++) begin idle(); adv_n = 0; gw_n = 0; wd = 32'hDEAD_BEEF; tick("R6"); end
    idle(); proc_n = 0; s2n = 1; addr = 6'd9; tick("R6");
    idle(); gw_n = 0; wd = 32'hBAD0_BAD0; tick("R6");
    idle(); tick("R6");
    proc_read(8, 0, "R6");

    // R1 R2 R7: every start offset, both orders; write controls and controller strobe pulled on the start edge
    for (int l = 0; l < 2; l++) begin
      for (int a = 0; a < NW; a++) begin
        idle(); lin = l[0]; proc_n = 0; ctrl_n = 0; gw_n = 0; bwe_n = 0; lane_n = 4'h0;
        adv_n = 0; wd = 32'hFFFF_FFFF; addr = AW'(a); tick("R1");
        for (int k = 0; k < 3; k++) begin idle(); lin = l[0]; adv_n = 0; tick("R7"); end
        idle(); lin = l[0]; tick("R7");
        idle(); lin = l[0]; tick("R2");
      end
    end

    // R5 R10: all per-lane patterns, then a lane-strobe pattern without the enable
    for (int p = 0; p < 16; p++) begin
      idle(); ctrl_n = 0; bwe_n = 0; lane_n = p[3:0]; addr = AW'(32 + p); wd = pat(p, 7); tick("R5");
      idle(); adv_n = 0; bwe_n = 0; lane_n = ~p[3:0]; wd = pat(p, 9); tick("R10");
      idle(); ctrl_n = 0; bwe_n = 1; lane_n = 4'h0; addr = AW'(48 + p); wd = pat(p, 11); tick("R5");
      idle(); tick("R5");
    end
    for (int a = 32; a < NW; a += 4) proc_read(a, 0, "R10");

    // R1: write strobes ignored on the processor start, honoured on the next edge
    idle(); proc_n = 0; gw_n = 0; wd = 32'h1111_1111; addr = 6'd20; tick("R1");
    idle(); gw_n = 0; wd = pat(20, 3); tick("R1");
    idle(); tick("R1");
    proc_read(20, 1, "R1");

    // R3: both strobes low, processor wins; then a controller write start
    idle(); proc_n = 0; ctrl_n = 0; gw_n = 0; wd = 32'h2222_2222; addr = 6'd5; tick("R3");
    idle(); tick("R3");
    idle(); ctrl_n = 0; gw_n = 0; wd = pat(5, 4); addr = 6'd5; tick("R3");
    proc_read(5, 0, "R3");

    // R4: master select off gates the processor strobe
    idle(); proc_n = 0; addr = 6'd12; tick("R4");
    idle(); adv_n = 0; tick("R4");
    idle(); proc_n = 0; s0n = 1; adv_n = 0; addr = 6'd40; tick("R4");
    idle(); tick("R4");
    idle(); proc_n = 0; ctrl_n = 0; s0n = 1; addr = 6'd41; tick("R4");
    idle(); adv_n = 0; tick("R4");
    idle(); tick("R4");

    // R8: a write right after a read mutes the output even with oe low
    idle(); proc_n = 0; addr = 6'd3; tick("R8");
    idle(); gw_n = 0; wd = pat(3, 5); tick("R8");
    idle(); tick("R8");
    proc_read(3, 0, "R8");

    // R9: output enable acts between clock edges
    idle(); proc_n = 0; addr = 6'd17; tick("R9");
    idle(); oe_n = 1; tick("R9");
    oe_n = 0; #1;
    check(drive_o === 1'b1, "R9", "drive_o after oe low", {31'd0, drive_o}, 32'd1);
    check(dq_o === last_dq, "R9", "dq_o after oe low", dq_o, last_dq);
    idle(); tick("R9");
    idle(); proc_n = 0; addr = 6'd18; tick("R9");
    idle(); tick("R9");
    oe_n = 1; #1;
    check(drive_o === 1'b0, "R9", "drive_o after oe high", {31'd0, drive_o}, 32'd0);
    oe_n = 0;

    // R11: reset in mid-run closes the cycle; continuation writes must not land
    idle(); proc_n = 0; addr = 6'd0; tick("R11");
    rst = 1; idle(); tick("R11"); tick("R11");
    rst = 0;
    for (int k = 0; k < 3; k++) begin idle(); adv_n = 0; gw_n = 0; wd = 32'hFFFF_FFFF; tick("R11"); end
    proc_read(0, 0, "R11");
    proc_read(1, 1, "R11");

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    n_tests++;
    $display("FAIL watchdog (all requirements): actual running expected finished");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule